// File: doc/BRIEF.md
# Battery Switch Control Register

This block holds the software-visible control word for the two series switches of a battery pack: the one that passes charge current and the one that passes discharge current. Firmware writes the word through a simple write-enable port and reads a registered copy back. Hardware can override what was written. An active current-protection condition, or an internal reset, forces the switches safe. It also forces the charge driver out of its deep under-voltage recovery mode.

The stored enables also decide which current detectors may run. The three discharge-side detectors (short circuit, high current, over current) run only while discharge is enabled. The two charge-side detectors (high current, over current) run while charge is enabled, or while the charge driver is in recovery mode.

Every output is a flop, loaded from the same next-state value. A write or an input change becomes visible on all outputs together, one clock later.

Top module: `batt_switch_ctl`

## Requirements
- R1: Synchronous reset `rst` wins over every other input. In the cycle after a reset edge, `rd_data_o` is 0x08 and every other output is 0.
- R2: The readback layout is: bit 3 = effective recovery-disable, bit 2 = protection status, bit 1 = discharge enable, bit 0 = charge enable. A write stores bits 3, 1 and 0 of `wr_data_i`, and the new value appears one cycle after the write. Bits 7 to 4 always read 0, whatever is written.
- R3: Bit 2 of `rd_data_o` equals `prot_act_i` as sampled at the previous clock edge. Writing bit 2 has no effect.
- R4: While `prot_act_i` is high, both stored enables are cleared. A write of one in the same cycle loses. The enables stay cleared after protection ends until software writes them again.
- R5: The effective recovery-disable value is the stored bit ORed with `prot_act_i` and `int_rst_i`. When the override is released, the stored value shows again. `rcv_mode_o` is the inverse of the effective value.
- R6: Each of `chg_drv_o` and `dsg_drv_o` is its stored enable ANDed with NOT `int_rst_i` and NOT `prot_act_i`, and appears one cycle after its cause.
- R7: Every bit of `dsg_det_en_o` equals the stored discharge enable.
- R8: Every bit of `chg_det_en_o` is one when the stored charge enable is one, or when the effective recovery-disable is zero. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_rst_i | input | 1 | Internal reset request; holds the switches off |
| prot_act_i | input | 1 | Current protection active |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Registered readback |
| chg_drv_o | output | 1 | Charge switch drive |
| dsg_drv_o | output | 1 | Discharge switch drive |
| rcv_mode_o | output | 1 | Charge driver in deep under-voltage recovery mode |
| dsg_det_en_o | output | N_DSG_DET | Discharge detector enables: bit 0 short circuit, bit 1 high current, bit 2 over current |
| chg_det_en_o | output | N_CHG_DET | Charge detector enables: bit 0 high current, bit 1 over current |

## Verification
The properties assume that `prot_act_i` and `int_rst_i` are synchronous levels that are stable around the clock edge. They also assume that a single-cycle write strobe carries a full word. The bench drives every input on the falling edge, so each value is settled before the rising edge that samples it. Each pulse lasts exactly one cycle, unless a case is holding a level on purpose. Simultaneous write-and-trip cases are built by raising both inputs in the same falling-edge slot.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_CHG  = 0;
  localparam int BIT_DSG  = 1;
  localparam int BIT_STAT = 2;
  localparam int BIT_RDIS = 3;

  typedef struct packed {
    logic rdis;
    logic dsg;
    logic chg;
  } bsc_bits_t;

  localparam bsc_bits_t BITS_RST = '{rdis: 1'b1, dsg: 1'b0, chg: 1'b0};
endpackage

// File: rtl/bsc_bits.sv
module bsc_bits
  import bsc_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            prot,
  output bsc_bits_t       bits_d
);
  bsc_bits_t bits_q;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) begin
      bits_d.rdis = wr_data[BIT_RDIS];
      bits_d.dsg  = wr_data[BIT_DSG];
      bits_d.chg  = wr_data[BIT_CHG];
    end
    if (prot) begin
      bits_d.dsg = 1'b0;
      bits_d.chg = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= BITS_RST;
    else     bits_q <= bits_d;
  end
endmodule

// File: rtl/bsc_outs.sv
module bsc_outs
  import bsc_pkg::*;
#(
  parameter int W         = REG_W,
  parameter int N_DSG_DET = 3,
  parameter int N_CHG_DET = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bsc_bits_t            bits_d,
  input  logic                 prot,
  input  logic                 irst,
  output logic [W-1:0]         rd_data,
  output logic                 chg_drv,
  output logic                 dsg_drv,
  output logic                 rcv_mode,
  output logic [N_DSG_DET-1:0] dsg_det,
  output logic [N_CHG_DET-1:0] chg_det
);
  localparam logic [W-1:0] RD_RST = W'(1) << BIT_RDIS;

  logic         eff_dis;
  logic         chg_gate;
  logic [W-1:0] rd_n;

  always_comb begin
    eff_dis            = bits_d.rdis | prot | irst;
    chg_gate           = bits_d.chg | ~eff_dis;
    rd_n               = '0;
    rd_n[BIT_RDIS]     = eff_dis;
    rd_n[BIT_STAT]     = prot;
    rd_n[BIT_DSG]      = bits_d.dsg;
    rd_n[BIT_CHG]      = bits_d.chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= RD_RST;
      chg_drv  <= 1'b0;
      dsg_drv  <= 1'b0;
      rcv_mode <= 1'b0;
    end else begin
      rd_data  <= rd_n;
      chg_drv  <= bits_d.chg & ~irst & ~prot;
      dsg_drv  <= bits_d.dsg & ~irst & ~prot;
      rcv_mode <= ~eff_dis;
    end
  end

  for (genvar g = 0; g < N_DSG_DET; g++) begin : g_dsg_det
    always_ff @(posedge clk) begin
      if (rst) dsg_det[g] <= 1'b0;
      else     dsg_det[g] <= bits_d.dsg;
    end
  end

  for (genvar g = 0; g < N_CHG_DET; g++) begin : g_chg_det
    always_ff @(posedge clk) begin
      if (rst) chg_det[g] <= 1'b0;
      else     chg_det[g] <= chg_gate;
    end
  end
endmodule

// File: rtl/batt_switch_ctl.sv
module batt_switch_ctl
  import bsc_pkg::*;
#(
  parameter int N_DSG_DET = 3,
  parameter int N_CHG_DET = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 int_rst_i,
  input  logic                 prot_act_i,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 chg_drv_o,
  output logic                 dsg_drv_o,
  output logic                 rcv_mode_o,
  output logic [N_DSG_DET-1:0] dsg_det_en_o,
  output logic [N_CHG_DET-1:0] chg_det_en_o
);
  bsc_bits_t bits_d;

  bsc_bits #(.W(REG_W)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .prot    (prot_act_i),
    .bits_d  (bits_d)
  );

  bsc_outs #(
    .W         (REG_W),
    .N_DSG_DET (N_DSG_DET),
    .N_CHG_DET (N_CHG_DET)
  ) u_outs (
    .clk      (clk),
    .rst      (rst),
    .bits_d   (bits_d),
    .prot     (prot_act_i),
    .irst     (int_rst_i),
    .rd_data  (rd_data_o),
    .chg_drv  (chg_drv_o),
    .dsg_drv  (dsg_drv_o),
    .rcv_mode (rcv_mode_o),
    .dsg_det  (dsg_det_en_o),
    .chg_det  (chg_det_en_o)
  );
endmodule

// File: rtl/batt_switch_ctl_chk.sv
module batt_switch_ctl_chk
  import bsc_pkg::*;
#(
  parameter int N_DSG_DET = 3,
  parameter int N_CHG_DET = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 int_rst_i,
  input logic                 prot_act_i,
  input logic [REG_W-1:0]     rd_data_o,
  input logic                 chg_drv_o,
  input logic                 dsg_drv_o,
  input logic                 rcv_mode_o,
  input logic [N_DSG_DET-1:0] dsg_det_en_o,
  input logic [N_CHG_DET-1:0] chg_det_en_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  reset_view_chk: assert property (@(posedge clk)
    armed && $past(rst) |-> rd_data_o == 8'h08 && !chg_drv_o && !dsg_drv_o && !rcv_mode_o);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> rd_data_o[REG_W-1:4] == '0);

  // R3
  status_track_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |-> rd_data_o[BIT_STAT] == $past(prot_act_i));

  // R4
  trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(prot_act_i) |-> rd_data_o[BIT_DSG:BIT_CHG] == 2'b00);

  // R5
  rdis_force_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(prot_act_i) || $past(int_rst_i)) |-> rd_data_o[BIT_RDIS] && !rcv_mode_o);

  // R5
  rcv_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> rcv_mode_o == !rd_data_o[BIT_RDIS]);

  // R6
  drive_safe_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(prot_act_i) || $past(int_rst_i)) |-> !chg_drv_o && !dsg_drv_o);

  // R6
  drive_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (!chg_drv_o || rd_data_o[BIT_CHG]) && (!dsg_drv_o || rd_data_o[BIT_DSG]));

  // R7
  dsg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> dsg_det_en_o == {N_DSG_DET{rd_data_o[BIT_DSG]}});

  // R8
  chg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> chg_det_en_o == {N_CHG_DET{rd_data_o[BIT_CHG] | ~rd_data_o[BIT_RDIS]}});
endmodule

bind batt_switch_ctl batt_switch_ctl_chk #(
  .N_DSG_DET (N_DSG_DET),
  .N_CHG_DET (N_CHG_DET)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .int_rst_i    (int_rst_i),
  .prot_act_i   (prot_act_i),
  .rd_data_o    (rd_data_o),
  .chg_drv_o    (chg_drv_o),
  .dsg_drv_o    (dsg_drv_o),
  .rcv_mode_o   (rcv_mode_o),
  .dsg_det_en_o (dsg_det_en_o),
  .chg_det_en_o (chg_det_en_o)
);

// File: tb/batt_switch_ctl_test.sv
module batt_switch_ctl_test;
  localparam int NV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       int_rst_i = 1'b0;
  logic       prot_act_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       chg_drv_o, dsg_drv_o, rcv_mode_o;
  logic [2:0] dsg_det_en_o;
  logic [1:0] chg_det_en_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  batt_switch_ctl uut (.*);

  // vector: {wr, data[7:0], prot, irst, rd[7:0], chg_drv, dsg_drv, rcv_mode, dsg_det[2:0], chg_det[1:0]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h03, 1'b0, 1'b0, 8'h03, 1'b1, 1'b1, 1'b1, 3'b111, 2'b11}, // R2 R6 R7 R8 all on
    {1'b1, 8'hFF, 1'b0, 1'b0, 8'h0B, 1'b1, 1'b1, 1'b0, 3'b111, 2'b11}, // R2 reserved and status ignored
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R4 trip clears, R3 status
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R4 stays cleared
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 2'b11}, // R8 recovery mode gate
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R5 int reset forces
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 2'b11}, // R5 stored value returns
    {1'b1, 8'h01, 1'b0, 1'b1, 8'h09, 1'b0, 1'b0, 1'b0, 3'b000, 2'b11}, // R6 int reset blocks drive
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1, 3'b000, 2'b11}, // R6 drive returns
    {1'b1, 8'h02, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 1'b1, 3'b111, 2'b11}, // R7 discharge only
    {1'b1, 8'h0B, 1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R4 clear beats write
    {1'b1, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'b000, 2'b11}, // R3 status not writable
    {1'b1, 8'hF2, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 1'b1, 3'b111, 2'b11}, // R2 high bits dropped
    {1'b1, 8'h09, 1'b1, 1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R4 R5 both overrides
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 3'b000, 2'b00}, // R5 release
    {1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1, 3'b000, 2'b11}  // R6 charge only
  };

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input logic [15:0] e);
    cmp("R2 R3 R4 readback", rd_data_o, e[15:8]);
    cmp("R6 drives", {6'b0, chg_drv_o, dsg_drv_o}, {6'b0, e[7:6]});
    cmp("R5 rcv_mode", {7'b0, rcv_mode_o}, {7'b0, e[5]});
    cmp("R7 dsg_det", {5'b0, dsg_det_en_o}, {5'b0, e[4:2]});
    cmp("R8 chg_det", {6'b0, chg_det_en_o}, {6'b0, e[1:0]});
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic p, input logic i, input logic r);
    @(negedge clk);
    wr_en_i = w; wr_data_i = d; prot_act_i = p; int_rst_i = i; rst = r;
    @(negedge clk);
    wr_en_i = 1'b0; prot_act_i = 1'b0; int_rst_i = 1'b0; rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1 reset state
    step(1'b1, 8'h03, 1'b1, 1'b1, 1'b1);
    check_out({8'h08, 3'b000, 3'b000, 2'b00});

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][26], VEC[k][25:18], VEC[k][17], VEC[k][16], 1'b0);
      check_out(VEC[k][15:0]);
    end

    // R4 write of ones while protection held is lost; R5 stored zero reappears
    step(1'b1, 8'h03, 1'b1, 1'b0, 1'b0);
    check_out({8'h0C, 3'b000, 3'b000, 2'b00});
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check_out({8'h00, 3'b001, 3'b000, 2'b11});

    // R1 reset in mid-run beats a simultaneous write
    step(1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
    check_out({8'h03, 3'b111, 3'b111, 2'b11});
    step(1'b1, 8'h03, 1'b0, 1'b0, 1'b1);
    check_out({8'h08, 3'b000, 3'b000, 2'b00});

    report();
  end
endmodule